// File: doc/BRIEF.md
# Chip-Select Capable Output Port

This block is an eight-pin output port in which every pin can be handed to chip-select duty. It holds one output latch per pin. A configuration register marks each pin as a chip select or a plain output and chooses whether the pin is inverted. Inversion lets a pin serve as an active-high select. The pin level is the latch value XOR the pin's inversion bit, and it is registered once so that the pad never sees a combinational glitch.

Software changes latches through a write-only strobe register that sets and clears individual latches in a single write. It never has to read, modify and write back, so two agents that drive different pins cannot race each other. Reading the strobe address returns the current latch values. The chip-select selection is only passed on to the pad multiplexing. The port does not decode select numbers and does no framing of its own.

Top module: `gpcs_port`

## Requirements
- R1: After reset the configuration reads 0x0000, every latch reads 1 (strobe readback 0x00FF), `pin_out` is 0xFF and `cs_sel` is 0x00.
- R2: A write to address 0 (configuration) stores all 16 bits, and a read of address 0 returns them.
- R3: Configuration bit 8+n drives `cs_sel[n]`, which marks pin n as a chip select.
- R4: A strobe write (address 1) with bit 8+n set to 1 sets latch n to 1.
- R5: A strobe write with bit n set to 1 clears latch n to 0.
- R6: A latch whose set bit and clear bit are both 0 in a strobe write keeps its value, and no latch changes without a strobe write.
- R7: When the set bit and the clear bit of the same pin are both 1, the latch is cleared.
- R8: `pin_out[n]` equals latch n XOR configuration bit n. It changes on the clock edge after the edge that updated the latch or the configuration.
- R9: A read of address 1 returns the latches in bits 7:0 and zeros in bits 15:8.
- R10: A strobe write of 0xFF00 drives all eight latches to 1.
- R11: A configuration write leaves the latches unchanged, and a strobe write leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 configuration, 1 set/clear strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pin_out | output | 8 | Registered pin levels |
| cs_sel | output | 8 | Per-pin chip-select mode flags |

## Verification
The assertions assume that `reg_wr`, `reg_addr` and `reg_wdata` are stable across each rising edge and are never unknown while reset is released. The bench meets this by changing them only on falling edges. The next-cycle checks on the latches, the configuration and the pins rely on one register access per cycle. The bench issues exactly one write per cycle and leaves `reg_wr` low between writes. That also exercises the hold-when-idle property.

// File: rtl/gpcs_pkg.sv
package gpcs_pkg;
  localparam int unsigned ADDR_W   = 1;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_STB = 1'b1;

  // next value of one latch bit: clear dominates set, neither holds
  function automatic logic latch_next(input logic cur, input logic set_b, input logic clr_b);
    logic r;
    if (clr_b)      r = 1'b0;
    else if (set_b) r = 1'b1;
    else            r = cur;
    return r;
  endfunction

  // pad level of one pin from its latch and inversion bit
  function automatic logic pin_level(input logic lat, input logic inv);
    return lat ^ inv;
  endfunction
endpackage

// File: rtl/gpcs_regfile.sv
module gpcs_regfile
  import gpcs_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  localparam int unsigned DW   = 2 * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NPINS-1:0]  latch_in,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     cfg_q,
  output logic              stb_wr,
  output logic [NPINS-1:0]  stb_set,
  output logic [NPINS-1:0]  stb_clr
);
  logic cfg_wr;

  assign cfg_wr  = wr_en && (addr == ADDR_CFG);
  assign stb_wr  = wr_en && (addr == ADDR_STB);
  assign stb_set = wdata[DW-1:NPINS];
  assign stb_clr = wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= wdata;
  end

  always_comb begin
    if (addr == ADDR_CFG) rdata = cfg_q;
    else                  rdata = {{NPINS{1'b0}}, latch_in};
  end

  // R2: a configuration write lands in full
  a_r2_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_q == $past(wdata));
  // R11: a strobe write does not touch the configuration
  a_r11_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    stb_wr |=> $stable(cfg_q));
endmodule

// File: rtl/gpcs_latch_bank.sv
module gpcs_latch_bank
  import gpcs_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_wr,
  input  logic [NPINS-1:0] set_v,
  input  logic [NPINS-1:0] clr_v,
  output logic [NPINS-1:0] latch_q
);
  for (genvar n = 0; n < NPINS; n++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q[n] <= 1'b1;
      else if (stb_wr) latch_q[n] <= latch_next(latch_q[n], set_v[n], clr_v[n]);
    end
  end

  // R5 / R7: any requested clear leaves the bit at zero, set or not
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stb_wr |=> (latch_q & $past(clr_v)) == '0);
  // R4: a set without a clear leaves the bit at one
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    stb_wr |=> (latch_q & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v));
  // R6: untouched bits hold during a strobe write
  a_r6_hold_bits: assert property (@(posedge clk) disable iff (!rst_n)
    stb_wr |=> ((latch_q ^ $past(latch_q)) & ~$past(set_v | clr_v)) == '0);
  // R6 / R11: no strobe write, no latch change
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_wr |=> $stable(latch_q));
endmodule

// File: rtl/gpcs_pin_stage.sv
module gpcs_pin_stage
  import gpcs_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] latch_in,
  input  logic [NPINS-1:0] inv_in,
  output logic [NPINS-1:0] pin_q
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q[n] <= 1'b1;
      else        pin_q[n] <= pin_level(latch_in[n], inv_in[n]);
    end
  end

  // R8: pad level follows latch XOR inversion one edge later
  a_r8_pin_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pin_q == $past(latch_in ^ inv_in));
endmodule

// File: rtl/gpcs_port.sv
module gpcs_port
  import gpcs_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  localparam int unsigned DW   = 2 * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  cs_sel
);
  logic [DW-1:0]    cfg_q;
  logic             stb_wr;
  logic [NPINS-1:0] stb_set, stb_clr, latch_q;

  gpcs_regfile #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .latch_in(latch_q), .rdata(reg_rdata),
    .cfg_q(cfg_q), .stb_wr(stb_wr), .stb_set(stb_set), .stb_clr(stb_clr));

  gpcs_latch_bank #(.NPINS(NPINS)) u_latch (
    .clk(clk), .rst_n(rst_n), .stb_wr(stb_wr),
    .set_v(stb_set), .clr_v(stb_clr), .latch_q(latch_q));

  gpcs_pin_stage #(.NPINS(NPINS)) u_pins (
    .clk(clk), .rst_n(rst_n), .latch_in(latch_q),
    .inv_in(cfg_q[NPINS-1:0]), .pin_q(pin_out));

  // R3: chip-select flags come from the upper configuration byte
  assign cs_sel = cfg_q[DW-1:NPINS];

  // R3: the mode flags move only on a configuration write
  a_r3_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(cs_sel));
endmodule

// File: tb/gpcs_port_tb.sv
module gpcs_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [0:0]  reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pin_out, cs_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  m_lat;
  logic [15:0] m_cfg;

  always #4 clk = ~clk;

  gpcs_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out), .cs_sel(cs_sel));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // independent model of one strobe write, bit by bit
  task automatic model_strobe(input logic [15:0] d);
    for (int n = 0; n < 8; n++) begin
      if (d[n])        m_lat[n] = 1'b0;
      else if (d[8+n]) m_lat[n] = 1'b1;
    end
  endtask

  function automatic logic [7:0] exp_pins(input logic [7:0] l, input logic [15:0] c);
    logic [7:0] r;
    for (int n = 0; n < 8; n++) r[n] = (l[n] != c[n]);
    return r;
  endfunction

  task automatic full_check(input string tag);
    logic [15:0] v;
    @(negedge clk); // pin stage has now caught up
    rd(1'b1, v);
    chk({tag, " R9 latches"}, v, {8'h00, m_lat});
    rd(1'b0, v);
    chk({tag, " R2 cfg"}, v, m_cfg);
    chk({tag, " R8 pins"}, {8'h00, pin_out}, {8'h00, exp_pins(m_lat, m_cfg)});
    chk({tag, " R3 cs_sel"}, {8'h00, cs_sel}, {8'h00, m_cfg[15:8]});
  endtask

  initial begin
    logic [15:0] v;
    m_lat = 8'hFF; m_cfg = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, v); chk("R1 cfg reset", v, 16'h0000);
    rd(1'b1, v); chk("R1 latch reset", v, 16'h00FF);
    chk("R1 pins reset", {8'h00, pin_out}, 16'h00FF);
    chk("R1 cs_sel reset", {8'h00, cs_sel}, 16'h0000);

    // R5 and R8 timing: clear all, pins lag by one edge
    wr(1'b1, 16'h00FF); model_strobe(16'h00FF);
    chk("R8 pins not yet moved", {8'h00, pin_out}, 16'h00FF);
    rd(1'b1, v); chk("R5 clear all", v, 16'h0000);
    @(negedge clk);
    chk("R8 pins after one edge", {8'h00, pin_out}, 16'h0000);

    // R10 all high
    wr(1'b1, 16'hFF00); model_strobe(16'hFF00); full_check("R10 all set");
    // R7 clear wins on every pin
    wr(1'b1, 16'hFFFF); model_strobe(16'hFFFF); full_check("R7 both bits");
    rd(1'b1, v); chk("R7 all cleared", v, 16'h0000);
    // R4 partial set, R6 zero write holds
    wr(1'b1, 16'hA500); model_strobe(16'hA500); full_check("R4 set A5");
    wr(1'b1, 16'h0000); model_strobe(16'h0000); full_check("R6 zero write");
    rd(1'b1, v); chk("R6 unchanged", v, 16'h00A5);
    // R11 config write leaves latches, strobe leaves config
    wr(1'b0, 16'h3C0F); m_cfg = 16'h3C0F; full_check("R11 cfg write");
    rd(1'b1, v); chk("R11 latches kept", v, 16'h00A5);
    wr(1'b1, 16'h5A5A); model_strobe(16'h5A5A); full_check("R11 strobe write");
    rd(1'b0, v); chk("R11 cfg kept", v, 16'h3C0F);

    // sweep: every set byte against a varied clear byte and configuration
    for (int i = 0; i < 256; i++) begin
      logic [15:0] c, s;
      c = {8'(i ^ 8'h5A), 8'(~i)};
      s = {8'(i), 8'((i * 37 + 11) & 255)};
      wr(1'b0, c); m_cfg = c;
      wr(1'b1, s); model_strobe(s);
      full_check("sweep R4 R5 R7");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule